// File: doc/BRIEF.md
# SDRAM Row Scheduler and Address Multiplexer

This block sits between a simple request port and the command pins of a four-bank SDRAM that has 32-bit words. A request carries a flat word address and a read/write flag. The block splits the address into a bank, a row and a column. It keeps a table with the open row of each bank. From that table it emits the command sequence the request needs: a column command alone, ACTIVE and then a column command, or PRECHARGE, ACTIVE and then a column command.

The block computes the waits between commands at elaboration time. Each wait is a ceiling of a nanosecond-scale timing value, given in picoseconds, divided by the clock period. NOP commands fill every cycle of a wait. The request port uses a valid/ready handshake. Ready stays low while a sequence is still in flight, so a new request waits until the current one has issued its column command. Refresh, initialization, mode programming and data movement are handled elsewhere.

Top module: `sdram_row_sched`

## Requirements
- R1: While reset is asserted, the chip-select output is high (deselect) and `reqReady` is high.
- R2: A request address is split as bank = `reqAddr[21:20]`, row = `reqAddr[19:8]`, column = `reqAddr[7:0]`. The bank always appears on `cmdBa` with ACTIVE, PRECHARGE, READ and WRITE.
- R3: Commands are encoded on {csN,rasN,casN,weN} as NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100 and PRECHARGE=0010. Every cycle that issues no command is a NOP.
- R4: A request to a bank with no open row issues ACTIVE in the cycle after acceptance, with the row on `cmdAddr`.
- R5: A column command follows its ACTIVE exactly TRCD_CYC = ceil(TRCD_PS/CLK_PS) cycles later (3 by default), with NOPs in between. No column command ever reaches a bank sooner than that after its ACTIVE.
- R6: READ and WRITE carry the column on `cmdAddr[7:0]` and zeros on `cmdAddr[11:8]`, so A10 is low and no auto-precharge occurs.
- R7: A request that hits the open row of its bank issues its READ or WRITE in the cycle after acceptance, with no ACTIVE, and `reqReady` stays high.
- R8: A request to a bank whose open row differs issues PRECHARGE to that bank (A10 low) in the cycle after acceptance. ACTIVE follows TRP_CYC = ceil(TRP_PS/CLK_PS) cycles later, and the column command comes TRCD_CYC cycles after the ACTIVE.
- R9: After a miss is accepted, `reqReady` stays low until the column command has been issued. A request held valid in that time is not taken, and every accepted request drives a non-NOP command in the next cycle.
- R10: Banks are tracked independently. Opening or closing a row in one bank leaves the open rows of the other banks in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 22 | Flat word address {bank,row,column} |
| reqReady | output | 1 | Request accepted on this edge when valid |
| cmdCsN | output | 1 | Chip select, active low |
| cmdRasN | output | 1 | Row strobe, active low |
| cmdCasN | output | 1 | Column strobe, active low |
| cmdWeN | output | 1 | Write enable, active low |
| cmdBa | output | 2 | Bank select |
| cmdAddr | output | 12 | Multiplexed row/column address |

## Verification
All command outputs are registered. The first command of any sequence is therefore due in the cycle that follows the accepting edge. After that, PRECHARGE leads ACTIVE by TRP_CYC cycles and ACTIVE leads the column command by TRCD_CYC cycles. When a request is accepted, the bench works out the full cycle-by-cycle sequence, including every filler NOP and the expected ready level in each cycle, and queues it. Each falling edge then compares exactly one queued cycle with the pins, so any shift of a single cycle in a wait is a mismatch.

// File: rtl/sdram_sched_pkg.sv
package sdram_sched_pkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic latch;   // capture incoming request
    logic fromIn;  // use incoming fields rather than latched ones
    logic act;     // issue ACTIVE
    logic pre;     // issue PRECHARGE
    logic col;     // issue READ or WRITE
  } strobe_t;

  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_ACT   = 4'b0011,
    CMD_PRE   = 4'b0010,
    CMD_RD    = 4'b0101,
    CMD_WR    = 4'b0100,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } cmd_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/sdram_sched_ctl.sv
module sdram_sched_ctl
  import sdram_sched_pkg::*;
#(
  parameter int TRCD_CYC = 3,
  parameter int TRP_CYC  = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    hitIn,
  input  logic    openIn,
  output logic    reqReady,
  output strobe_t strb
);

  localparam int MAX_CYC = (TRCD_CYC > TRP_CYC) ? TRCD_CYC : TRP_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT_RP, ST_WAIT_RCD} state_t;

  state_t             state, stateNext;
  logic [CNT_W-1:0]   waitCnt, waitCntNext;

  always_comb begin
    strb        = '0;
    stateNext   = state;
    waitCntNext = waitCnt;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.latch  = 1'b1;
          strb.fromIn = 1'b1;
          if (hitIn) begin
            strb.col = 1'b1;
          end else if (openIn) begin
            strb.pre    = 1'b1;
            stateNext   = ST_WAIT_RP;
            waitCntNext = CNT_W'(TRP_CYC - 1);
          end else begin
            strb.act    = 1'b1;
            stateNext   = ST_WAIT_RCD;
            waitCntNext = CNT_W'(TRCD_CYC - 1);
          end
        end
      end
      ST_WAIT_RP: begin
        if (waitCnt == '0) begin
          strb.act    = 1'b1;
          stateNext   = ST_WAIT_RCD;
          waitCntNext = CNT_W'(TRCD_CYC - 1);
        end else begin
          waitCntNext = waitCnt - 1'b1;
        end
      end
      ST_WAIT_RCD: begin
        if (waitCnt == '0) begin
          strb.col  = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          waitCntNext = waitCnt - 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitCntNext;
    end
  end

  assign reqReady = (state == ST_IDLE);

endmodule

// File: rtl/sdram_sched_dp.sv
module sdram_sched_dp
  import sdram_sched_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W,
  localparam int NBANK  = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic              inWrite,
  output logic              hitIn,
  output logic              openIn,
  output logic              cmdCsN,
  output logic              cmdRasN,
  output logic              cmdCasN,
  output logic              cmdWeN,
  output logic [BANK_W-1:0] cmdBa,
  output logic [ROW_W-1:0]  cmdAddr
);

  logic [BANK_W-1:0] inBank, hBank, srcBank;
  logic [ROW_W-1:0]  inRow,  hRow,  srcRow;
  logic [COL_W-1:0]  inCol,  hCol,  srcCol;
  logic              hWrite, srcWrite;

  logic              openV   [NBANK];
  logic [ROW_W-1:0]  openRow [NBANK];

  assign {inBank, inRow, inCol} = inAddr;

  // Held request for multi-command sequences
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hBank  <= '0;
      hRow   <= '0;
      hCol   <= '0;
      hWrite <= 1'b0;
    end else if (strb.latch) begin
      hBank  <= inBank;
      hRow   <= inRow;
      hCol   <= inCol;
      hWrite <= inWrite;
    end
  end

  assign srcBank  = strb.fromIn ? inBank  : hBank;
  assign srcRow   = strb.fromIn ? inRow   : hRow;
  assign srcCol   = strb.fromIn ? inCol   : hCol;
  assign srcWrite = strb.fromIn ? inWrite : hWrite;

  // Per-bank open-row table
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        openV[g]   <= 1'b0;
        openRow[g] <= '0;
      end else if (strb.act && (srcBank == BANK_W'(g))) begin
        openV[g]   <= 1'b1;
        openRow[g] <= srcRow;
      end else if (strb.pre && (srcBank == BANK_W'(g))) begin
        openV[g]   <= 1'b0;
      end
    end
  end

  assign openIn = openV[inBank];
  assign hitIn  = openV[inBank] && (openRow[inBank] == inRow);

  // Registered command pins
  cmd_t              cmdNext;
  logic [BANK_W-1:0] baNext;
  logic [ROW_W-1:0]  addrNext;

  always_comb begin
    cmdNext  = CMD_NOP;
    baNext   = '0;
    addrNext = '0;
    if (strb.act) begin
      cmdNext  = CMD_ACT;
      baNext   = srcBank;
      addrNext = srcRow;
    end else if (strb.pre) begin
      cmdNext  = CMD_PRE;
      baNext   = srcBank;
    end else if (strb.col) begin
      cmdNext  = srcWrite ? CMD_WR : CMD_RD;
      baNext   = srcBank;
      addrNext = {{(ROW_W-COL_W){1'b0}}, srcCol};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {cmdCsN, cmdRasN, cmdCasN, cmdWeN} <= CMD_DESEL;
      cmdBa   <= '0;
      cmdAddr <= '0;
    end else begin
      {cmdCsN, cmdRasN, cmdCasN, cmdWeN} <= cmdNext;
      cmdBa   <= baNext;
      cmdAddr <= addrNext;
    end
  end

endmodule

// File: rtl/sdram_row_sched.sv
module sdram_row_sched
  import sdram_sched_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int CLK_PS  = 8000,
  parameter int TRCD_PS = 18000,
  parameter int TRP_PS  = 18000,
  localparam int ADDR_W   = BANK_W + ROW_W + COL_W,
  localparam int TRCD_CYC = ceilDiv(TRCD_PS, CLK_PS),
  localparam int TRP_CYC  = ceilDiv(TRP_PS, CLK_PS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              cmdCsN,
  output logic              cmdRasN,
  output logic              cmdCasN,
  output logic              cmdWeN,
  output logic [BANK_W-1:0] cmdBa,
  output logic [ROW_W-1:0]  cmdAddr
);

  strobe_t strb;
  logic    hitIn, openIn;

  sdram_sched_ctl #(.TRCD_CYC(TRCD_CYC), .TRP_CYC(TRP_CYC)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .hitIn(hitIn), .openIn(openIn),
    .reqReady(reqReady), .strb(strb)
  );

  sdram_sched_dp #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .inAddr(reqAddr), .inWrite(reqWrite),
    .hitIn(hitIn), .openIn(openIn),
    .cmdCsN(cmdCsN), .cmdRasN(cmdRasN), .cmdCasN(cmdCasN), .cmdWeN(cmdWeN),
    .cmdBa(cmdBa), .cmdAddr(cmdAddr)
  );

endmodule

// File: rtl/sdram_sched_chk.sv
module sdram_sched_chk #(
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 12,
  parameter int TRCD_CYC = 3,
  parameter int TRP_CYC  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              cmdCsN,
  input logic              cmdRasN,
  input logic              cmdCasN,
  input logic              cmdWeN,
  input logic [BANK_W-1:0] cmdBa,
  input logic [ROW_W-1:0]  cmdAddr
);

  localparam int NBANK = 1 << BANK_W;
  localparam logic [15:0] SAT = 16'hFFFF;

  logic [3:0] cmd;
  logic       isAct, isPre, isCol;
  assign cmd   = {cmdCsN, cmdRasN, cmdCasN, cmdWeN};
  assign isAct = (cmd == 4'b0011);
  assign isPre = (cmd == 4'b0010);
  assign isCol = (cmd == 4'b0101) || (cmd == 4'b0100);

  logic [15:0] sinceAct [NBANK];
  logic [15:0] sincePre [NBANK];
  logic        bankOpen [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_trk
    always_ff @(posedge clk) begin
      if (!rstN) begin
        sinceAct[g] <= SAT;
        sincePre[g] <= SAT;
        bankOpen[g] <= 1'b0;
      end else begin
        if (isAct && cmdBa == BANK_W'(g)) begin
          sinceAct[g] <= 16'd1;
          bankOpen[g] <= 1'b1;
        end else if (sinceAct[g] != SAT) begin
          sinceAct[g] <= sinceAct[g] + 16'd1;
        end
        if (isPre && cmdBa == BANK_W'(g)) begin
          sincePre[g] <= 16'd1;
          bankOpen[g] <= 1'b0;
        end else if (sincePre[g] != SAT) begin
          sincePre[g] <= sincePre[g] + 16'd1;
        end
      end
    end
  end

  // R3
  legal_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdCsN |-> (cmd == 4'b0111 || isAct || isPre || isCol));

  // R5
  act_to_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    isCol |-> (sinceAct[cmdBa] >= 16'(TRCD_CYC)));

  // R5
  col_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    isCol |-> bankOpen[cmdBa]);

  // R8
  pre_to_act_chk: assert property (@(posedge clk) disable iff (!rstN)
    isAct |-> (sincePre[cmdBa] >= 16'(TRP_CYC)));

  // R4
  act_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    isAct |-> !bankOpen[cmdBa]);

  // R6
  no_autopre_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isCol || isPre) |-> (cmdAddr[10] == 1'b0));

  // R9
  accept_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (isAct || isPre || isCol));

endmodule

bind sdram_row_sched sdram_sched_chk #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .TRCD_CYC(TRCD_CYC), .TRP_CYC(TRP_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .cmdCsN(cmdCsN), .cmdRasN(cmdRasN), .cmdCasN(cmdCasN), .cmdWeN(cmdWeN),
  .cmdBa(cmdBa), .cmdAddr(cmdAddr)
);

// File: tb/sim_sdram_row_sched.sv
`timescale 1ns/1ps
module sim_sdram_row_sched;

  localparam int CLK_PS   = 8000;
  localparam int TRCD_PS  = 18000;
  localparam int TRP_PS   = 18000;
  localparam int TRCD_CYC = (TRCD_PS + CLK_PS - 1) / CLK_PS;
  localparam int TRP_CYC  = (TRP_PS + CLK_PS - 1) / CLK_PS;

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_PRE = 4'b0010,
                         C_RD  = 4'b0101, C_WR  = 4'b0100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [21:0] reqAddr = '0;
  logic        reqReady;
  logic        cmdCsN, cmdRasN, cmdCasN, cmdWeN;
  logic [1:0]  cmdBa;
  logic [11:0] cmdAddr;

  always #4 clk = ~clk;

  sdram_row_sched u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqReady(reqReady),
    .cmdCsN(cmdCsN), .cmdRasN(cmdRasN), .cmdCasN(cmdCasN), .cmdWeN(cmdWeN),
    .cmdBa(cmdBa), .cmdAddr(cmdAddr)
  );

  typedef struct {
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [11:0] a;
    logic        full;   // compare bank and address too
    logic        rdy;
    int          tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  logic started = 1'b0;
  logic done = 1'b0;

  logic        mOpen [4];
  logic [11:0] mRow  [4];

  task automatic pushItem(input logic [3:0] c, input logic [1:0] b,
                          input logic [11:0] a, input logic full,
                          input logic rdy, input int tag);
    exp_t e;
    e.cmd = c; e.ba = b; e.a = a; e.full = full; e.rdy = rdy; e.tag = tag;
    q.push_back(e);
  endtask

  // Driver: issues one request and queues the expected command cycles.
  task automatic sendReq(input logic wr, input logic [1:0] b,
                         input logic [11:0] r, input logic [7:0] c,
                         input int tag);
    logic [3:0] colCmd;
    @(negedge clk);
    reqAddr  = {b, r, c};   // R2 field split
    reqWrite = wr;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    colCmd = wr ? C_WR : C_RD;
    if (mOpen[b] && mRow[b] == r) begin
      // R7 hit
      pushItem(colCmd, b, {4'h0, c}, 1'b1, 1'b1, tag);
    end else begin
      if (mOpen[b]) begin
        // R8 conflict
        pushItem(C_PRE, b, 12'h000, 1'b1, 1'b0, tag);
        for (int i = 1; i < TRP_CYC; i++) pushItem(C_NOP, 2'b0, 12'h0, 1'b0, 1'b0, tag);
      end
      // R4 activate, R5 wait, R9 ready low
      pushItem(C_ACT, b, r, 1'b1, 1'b0, tag);
      for (int i = 1; i < TRCD_CYC; i++) pushItem(C_NOP, 2'b0, 12'h0, 1'b0, 1'b0, tag);
      pushItem(colCmd, b, {4'h0, c}, 1'b1, 1'b1, tag);  // R6 column form
      mOpen[b] = 1'b1;
      mRow[b]  = r;
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Monitor: compares one cycle per falling edge.
  always @(negedge clk) begin
    if (started && !done) begin
      exp_t e;
      logic [3:0] got;
      got = {cmdCsN, cmdRasN, cmdCasN, cmdWeN};
      if (q.size() > 0) begin
        e = q.pop_front();
      end else begin
        // R3 idle cycles are NOP with ready high
        e.cmd = C_NOP; e.ba = 0; e.a = 0; e.full = 1'b0; e.rdy = 1'b1; e.tag = 3;
      end
      checks++;
      if (got !== e.cmd || reqReady !== e.rdy ||
          (e.full && (cmdBa !== e.ba || cmdAddr !== e.a))) begin
        errors++;
        $display("FAIL R%0d: got cmd=%b ba=%0d a=%h rdy=%b, exp cmd=%b ba=%0d a=%h rdy=%b",
                 e.tag, got, cmdBa, cmdAddr, reqReady, e.cmd, e.ba, e.a, e.rdy);
      end
    end
  end

  // Watchdog
  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got running, exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mOpen[i] = 1'b0; mRow[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (cmdCsN !== 1'b1 || reqReady !== 1'b1) begin
      errors++;
      $display("FAIL R1: got csN=%b rdy=%b, exp csN=1 rdy=1", cmdCsN, reqReady);
    end
    rstN = 1'b1;
    @(negedge clk);
    started = 1'b1;

    sendReq(1'b0, 2'd0, 12'h005, 8'h12, 4);   // R4 closed bank, R5, R6
    sendReq(1'b1, 2'd0, 12'h005, 8'h34, 7);   // R7 hit, write
    sendReq(1'b0, 2'd0, 12'h005, 8'hFE, 7);   // R7 back-to-back hit
    sendReq(1'b0, 2'd2, 12'hABC, 8'hFF, 2);   // R2 bank/row field edges
    sendReq(1'b0, 2'd0, 12'h005, 8'h01, 10);  // R10 bank 0 still open
    sendReq(1'b1, 2'd0, 12'h007, 8'h40, 8);   // R8 conflict
    sendReq(1'b1, 2'd2, 12'hABC, 8'h00, 10);  // R10 bank 2 untouched
    sendReq(1'b0, 2'd3, 12'hFFF, 8'h00, 9);   // R9 miss holds ready low
    sendReq(1'b1, 2'd3, 12'hFFF, 8'h80, 7);   // R7
    sendReq(1'b0, 2'd2, 12'h000, 8'h55, 8);   // R8 conflict to row 0
    sendReq(1'b0, 2'd1, 12'h800, 8'hAA, 5);   // R5 fresh bank 1

    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule